// File: doc/BRIEF.md
# SD SPI Data Block Transmitter

This block carries the data phase of an SD card write in SPI mode. Once the write command has been issued elsewhere, a start pulse hands it a block count and a mode: single-block or multi-block. For each block it frames the payload with a filler byte and a start token. It pulls the payload bytes one at a time from a valid/ready stream and appends a CRC16 computed over the payload. It then polls for the card's data response token and waits until the card stops signalling busy.

Every byte goes through an external SPI byte shifter. The block raises a request with the byte to send, and the shifter answers with a done pulse and the byte it received. In multi-block mode, a run in which every block succeeded is closed with a stop token and a second busy wait. Each run ends with a one-cycle done pulse and a status code: success, rejected data, or timeout. Retries belong to the caller.

Top module: `sd_spi_blk_tx`

## Requirements
- R1: After reset, busy_o, done_o, xchg_req_o and data_ready_o are all low, and they stay low until a start is accepted.
- R2: Every block opens with two exchanges: first 0xFF, then a start token. The token is 0xFC when multi_i was high at start and 0xFE when it was low. A block count of zero is treated as one block.
- R3: Exactly BLK_BYTES payload bytes are taken from the stream for each block sent, one per handshake (data_valid_i and data_ready_o both high). data_ready_o is never high while an exchange request is pending. Each accepted byte is the tx byte of the next exchange.
- R4: The two exchanges after the payload carry the CRC16 of the payload, most significant byte first. The CRC uses polynomial 0x1021 with an initial value of 0. When crc_on_i was low at start, both bytes are sent as 0xFF.
- R5: After the CRC, the block sends 0xFF and reads until a received byte has bit 4 clear, for at most RESP_TRIES reads. The block is accepted only if the low five bits of that byte equal 0x05. Any other code (for example 0x0B or 0x0D), or no such byte within RESP_TRIES reads, ends the run with status 1.
- R6: After acceptance, the busy wait sends 0xFF and reads bytes. The first byte read is always ignored, whatever its value. The wait ends on the first later byte equal to 0xFF. If BUSY_LIMIT reads pass without that, the run ends with status 2.
- R7: In multi-block mode, once every block has passed its busy wait, the block sends 0xFF, then the stop token 0xFD, then runs a busy wait under the R6 rules. The stop token is never sent after a failed block.
- R8: A run ends with done_o high for exactly one cycle and busy_o low in that cycle. status_o is valid during the pulse: 0 means success, 1 means data rejected or no response, 2 means busy timeout.
- R9: start_i is ignored while busy_o is high. A start in the cycle where done_o is high is accepted.
- R10: While xchg_req_o is high and xchg_done_i is low, xchg_req_o stays high and xchg_tx_o stays unchanged. Every exchange outside the payload, token and CRC phases sends 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a write data phase (taken when idle) |
| multi_i | input | 1 | Multi-block mode, sampled at start |
| crc_on_i | input | 1 | Send real CRC16 (1) or 0xFFFF (0), sampled at start |
| nblk_i | input | NBLK_W | Number of blocks, sampled at start (0 means 1) |
| data_i | input | 8 | Payload stream byte |
| data_valid_i | input | 1 | Payload byte valid |
| data_ready_o | output | 1 | Block takes a payload byte |
| xchg_req_o | output | 1 | Byte exchange request to the SPI shifter |
| xchg_tx_o | output | 8 | Byte to send in the pending exchange |
| xchg_done_i | input | 1 | Exchange finished (one-cycle pulse) |
| xchg_rx_i | input | 8 | Byte received in the finished exchange |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | 0 ok, 1 data rejected / no response, 2 busy timeout |

## Verification
Two of the block's functions can fall in the same cycle: the end of one run (the done pulse with its status) and the acceptance of the next start. The bench provokes this by chaining runs: it raises start_i during the very cycle it sees done_o high. It judges the result by checking that the finished run reports its expected status and exchange count, and that the new run's first exchange is the 0xFF filler followed by the correct token. Separately, a start pulse injected in the middle of a long multi-block run must leave every later exchange byte unchanged.

// File: rtl/sdw_pkg.sv
`timescale 1ns/1ps
package sdw_pkg;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_DATA_ERR = 2'd1,
    ST_TIMEOUT  = 2'd2
  } sdw_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FILL,
    S_TOKEN,
    S_PAY_GET,
    S_PAY_XCHG,
    S_CRC_HI,
    S_CRC_LO,
    S_RESP,
    S_BUSY,
    S_STOP_FILL,
    S_STOP_TOK
  } sdw_state_e;

  localparam logic [7:0]  FILL_BYTE  = 8'hFF;
  localparam logic [7:0]  TOK_SINGLE = 8'hFE;
  localparam logic [7:0]  TOK_MULTI  = 8'hFC;
  localparam logic [7:0]  TOK_STOP   = 8'hFD;
  localparam logic [4:0]  RESP_OK    = 5'h05;
  localparam logic [15:0] CRC_POLY   = 16'h1021;

  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/sdw_counter.sv
`timescale 1ns/1ps
module sdw_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

endmodule

// File: rtl/sdw_crc16.sv
`timescale 1ns/1ps
module sdw_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (upd_i) crc_o <= sdw_pkg::crc16_next(crc_o, byte_i);
  end

endmodule

// File: rtl/sdw_seq.sv
`timescale 1ns/1ps
module sdw_seq
  import sdw_pkg::*;
#(
  parameter int BLK_BYTES  = 512,
  parameter int RESP_TRIES = 8,
  parameter int BUSY_LIMIT = 3000000,
  parameter int NBLK_W     = 16,
  parameter int BYTE_W     = 10,
  parameter int POLL_W     = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              multi_i,
  input  logic              crc_on_i,
  input  logic [NBLK_W-1:0] nblk_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              xchg_req_o,
  output logic [7:0]        xchg_tx_o,
  input  logic              xchg_done_i,
  input  logic [7:0]        xchg_rx_i,
  input  logic [15:0]       crc_i,
  output logic              crc_clr_o,
  output logic              crc_upd_o,
  input  logic [BYTE_W-1:0] pay_cnt_i,
  output logic              pay_clr_o,
  output logic              pay_inc_o,
  input  logic [POLL_W-1:0] poll_cnt_i,
  output logic              poll_clr_o,
  output logic              poll_inc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o
);

  sdw_state_e        state_q;
  sdw_status_e       status_q;
  logic              multi_q, crc_on_q, stop_q, done_q;
  logic [NBLK_W-1:0] blk_left_q;
  logic [7:0]        pay_q;

  logic in_pay, in_poll, last_byte, resp_last, busy_last, first_read, rx_idle;

  assign in_pay     = (state_q == S_PAY_GET) || (state_q == S_PAY_XCHG);
  assign in_poll    = (state_q == S_RESP) || (state_q == S_BUSY);
  assign last_byte  = pay_cnt_i == BYTE_W'(BLK_BYTES - 1);
  assign resp_last  = poll_cnt_i == POLL_W'(RESP_TRIES - 1);
  assign busy_last  = poll_cnt_i == POLL_W'(BUSY_LIMIT - 1);
  assign first_read = poll_cnt_i == '0;
  assign rx_idle    = xchg_rx_i == FILL_BYTE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      status_q   <= ST_OK;
      multi_q    <= 1'b0;
      crc_on_q   <= 1'b0;
      stop_q     <= 1'b0;
      done_q     <= 1'b0;
      blk_left_q <= '0;
      pay_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          multi_q    <= multi_i;
          crc_on_q   <= crc_on_i;
          stop_q     <= 1'b0;
          blk_left_q <= (nblk_i == '0) ? NBLK_W'(1) : nblk_i;
          state_q    <= S_FILL;
        end
        S_FILL:    if (xchg_done_i) state_q <= S_TOKEN;
        S_TOKEN:   if (xchg_done_i) state_q <= S_PAY_GET;
        S_PAY_GET: if (data_valid_i) begin
          pay_q   <= data_i;
          state_q <= S_PAY_XCHG;
        end
        S_PAY_XCHG: if (xchg_done_i) state_q <= last_byte ? S_CRC_HI : S_PAY_GET;
        S_CRC_HI:   if (xchg_done_i) state_q <= S_CRC_LO;
        S_CRC_LO:   if (xchg_done_i) state_q <= S_RESP;
        S_RESP: if (xchg_done_i) begin
          if (!xchg_rx_i[4]) begin
            if (xchg_rx_i[4:0] == RESP_OK) begin
              state_q <= S_BUSY;
            end else begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= ST_DATA_ERR;
            end
          end else if (resp_last) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= ST_DATA_ERR;
          end
        end
        S_BUSY: if (xchg_done_i) begin
          if (!first_read && rx_idle) begin
            if (stop_q) begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= ST_OK;
            end else if (blk_left_q > NBLK_W'(1)) begin
              blk_left_q <= blk_left_q - NBLK_W'(1);
              state_q    <= S_FILL;
            end else if (multi_q) begin
              state_q <= S_STOP_FILL;
            end else begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= ST_OK;
            end
          end else if (busy_last) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= ST_TIMEOUT;
          end
        end
        S_STOP_FILL: if (xchg_done_i) state_q <= S_STOP_TOK;
        S_STOP_TOK: if (xchg_done_i) begin
          stop_q  <= 1'b1;
          state_q <= S_BUSY;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    xchg_req_o = 1'b1;
    xchg_tx_o  = FILL_BYTE;
    unique case (state_q)
      S_IDLE, S_PAY_GET: xchg_req_o = 1'b0;
      S_TOKEN:    xchg_tx_o = multi_q ? TOK_MULTI : TOK_SINGLE;
      S_PAY_XCHG: xchg_tx_o = pay_q;
      S_CRC_HI:   xchg_tx_o = crc_on_q ? crc_i[15:8] : FILL_BYTE;
      S_CRC_LO:   xchg_tx_o = crc_on_q ? crc_i[7:0]  : FILL_BYTE;
      S_STOP_TOK: xchg_tx_o = TOK_STOP;
      default:    xchg_tx_o = FILL_BYTE;
    endcase
  end

  assign data_ready_o = state_q == S_PAY_GET;
  assign crc_clr_o    = state_q == S_FILL;
  assign crc_upd_o    = (state_q == S_PAY_GET) && data_valid_i;
  assign pay_clr_o    = !in_pay;
  assign pay_inc_o    = (state_q == S_PAY_XCHG) && xchg_done_i;
  // counter restarts on leaving the response poll for the busy wait
  assign poll_clr_o   = !in_poll || ((state_q == S_RESP) && xchg_done_i && !xchg_rx_i[4]);
  assign poll_inc_o   = in_poll && xchg_done_i;

  assign busy_o   = state_q != S_IDLE;
  assign done_o   = done_q;
  assign status_o = status_q;

endmodule

// File: rtl/sd_spi_blk_tx.sv
`timescale 1ns/1ps
module sd_spi_blk_tx #(
  parameter int BLK_BYTES  = 512,
  parameter int RESP_TRIES = 8,
  parameter int BUSY_LIMIT = 3000000,
  parameter int NBLK_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              multi_i,
  input  logic              crc_on_i,
  input  logic [NBLK_W-1:0] nblk_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              xchg_req_o,
  output logic [7:0]        xchg_tx_o,
  input  logic              xchg_done_i,
  input  logic [7:0]        xchg_rx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o
);

  localparam int BYTE_W   = $clog2(BLK_BYTES + 1);
  localparam int POLL_MAX = (BUSY_LIMIT > RESP_TRIES) ? BUSY_LIMIT : RESP_TRIES;
  localparam int POLL_W   = $clog2(POLL_MAX + 1);

  logic [15:0]       crc;
  logic              crc_clr, crc_upd;
  logic [BYTE_W-1:0] pay_cnt;
  logic              pay_clr, pay_inc;
  logic [POLL_W-1:0] poll_cnt;
  logic              poll_clr, poll_inc;

  sdw_crc16 i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .byte_i (data_i),
    .crc_o  (crc)
  );

  sdw_counter #(.W(BYTE_W)) i_pay_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pay_clr),
    .inc_i  (pay_inc),
    .cnt_o  (pay_cnt)
  );

  sdw_counter #(.W(POLL_W)) i_poll_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .cnt_o  (poll_cnt)
  );

  sdw_seq #(
    .BLK_BYTES  (BLK_BYTES),
    .RESP_TRIES (RESP_TRIES),
    .BUSY_LIMIT (BUSY_LIMIT),
    .NBLK_W     (NBLK_W),
    .BYTE_W     (BYTE_W),
    .POLL_W     (POLL_W)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .multi_i      (multi_i),
    .crc_on_i     (crc_on_i),
    .nblk_i       (nblk_i),
    .data_i       (data_i),
    .data_valid_i (data_valid_i),
    .data_ready_o (data_ready_o),
    .xchg_req_o   (xchg_req_o),
    .xchg_tx_o    (xchg_tx_o),
    .xchg_done_i  (xchg_done_i),
    .xchg_rx_i    (xchg_rx_i),
    .crc_i        (crc),
    .crc_clr_o    (crc_clr),
    .crc_upd_o    (crc_upd),
    .pay_cnt_i    (pay_cnt),
    .pay_clr_o    (pay_clr),
    .pay_inc_o    (pay_inc),
    .poll_cnt_i   (poll_cnt),
    .poll_clr_o   (poll_clr),
    .poll_inc_o   (poll_inc),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .status_o     (status_o)
  );

endmodule

// File: rtl/sd_spi_blk_tx_chk.sv
`timescale 1ns/1ps
module sd_spi_blk_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [7:0] data_i,
  input logic       data_valid_i,
  input logic       data_ready_o,
  input logic       xchg_req_o,
  input logic [7:0] xchg_tx_o,
  input logic       xchg_done_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o
);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!xchg_req_o && !data_ready_o));

  a_r3_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> !xchg_req_o);

  a_r3_byte_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && data_ready_o) |=> (xchg_req_o && xchg_tx_o == $past(data_i)));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && status_o != 2'd3));

  a_r8_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r9_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_req_o && !xchg_done_i) |=> (xchg_req_o && $stable(xchg_tx_o)));

endmodule

bind sd_spi_blk_tx sd_spi_blk_tx_chk i_chk (.*);

// File: tb/test_sd_spi_blk_tx.sv
`timescale 1ns/1ps
module test_sd_spi_blk_tx;

  localparam int BLK   = 8;
  localparam int LIM   = 12;
  localparam int TRIES = 8;
  localparam int NW    = 4;
  localparam int MAXE  = 4096;
  localparam int NCASE = 15;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          start_i, multi_i, crc_on_i;
  logic [NW-1:0] nblk_i;
  logic [7:0]    data_i;
  logic          data_valid_i, data_ready_o;
  logic          xchg_req_o, xchg_done_i;
  logic [7:0]    xchg_tx_o, xchg_rx_i;
  logic          busy_o, done_o;
  logic [1:0]    status_o;

  always #2 clk_i = ~clk_i;

  sd_spi_blk_tx #(
    .BLK_BYTES(BLK), .RESP_TRIES(TRIES), .BUSY_LIMIT(LIM), .NBLK_W(NW)
  ) i_sd_spi_blk_tx (.*);

  logic [7:0] exp_tx [MAXE];
  logic [7:0] exp_rx [MAXE];
  int         exp_tag[MAXE];
  logic [7:0] pay    [MAXE];
  int ne = 0, np = 0, k = 0, pidx = 0, dc = 0;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  int c_nblk[NCASE], c_status[NCASE], c_end[NCASE];
  bit c_multi[NCASE], c_crc[NCASE], c_chain[NCASE];

  function automatic string tag_s(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[15] != b[7-i]) r = (r << 1) ^ 16'h1021;
      else                 r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] t, input logic [7:0] r, input int tag);
    exp_tx[ne] = t; exp_rx[ne] = r; exp_tag[ne] = tag; ne++;
  endtask

  task automatic busy_seq(input int kz, input logic [7:0] fb, input int tag, output bit to);
    put(8'hFF, fb, tag);
    if (kz + 2 <= LIM) begin
      for (int i = 0; i < kz; i++) put(8'hFF, 8'h00, tag);
      put(8'hFF, 8'hFF, tag);
      to = 0;
    end else begin
      for (int i = 0; i < LIM - 1; i++) put(8'hFF, 8'h00, tag);
      to = 1;
    end
  endtask

  task automatic add_case(input int c, input int nblk, input bit multi, input bit crcon,
                          input int rdly, input int bad_blk, input logic [7:0] bad_code,
                          input int busy_k, input logic [7:0] fb, input int to_blk,
                          input int stop_k, input bit chain);
    int eff, st;
    bit to, fail;
    logic [15:0] crc;
    logic [7:0]  b8, code;
    eff  = (nblk == 0) ? 1 : nblk;
    st   = 0;
    fail = 0;
    c_nblk[c] = nblk; c_multi[c] = multi; c_crc[c] = crcon; c_chain[c] = chain;
    for (int b = 0; b < eff && !fail; b++) begin
      put(8'hFF, 8'hFF, 2);
      put(multi ? 8'hFC : 8'hFE, 8'hFF, 2);
      crc = 16'h0;
      for (int i = 0; i < BLK; i++) begin
        b8 = 8'($urandom);
        pay[np++] = b8;
        crc = ref_crc(crc, b8);
        put(b8, 8'hFF, 3);
      end
      put(crcon ? crc[15:8] : 8'hFF, 8'hFF, 4);
      put(crcon ? crc[7:0]  : 8'hFF, 8'hFF, 4);
      code = (b == bad_blk) ? bad_code : 8'hE5;
      if (rdly >= TRIES) begin
        for (int i = 0; i < TRIES; i++) put(8'hFF, 8'hFF, 5);
        st = 1; fail = 1;
      end else begin
        for (int i = 0; i < rdly; i++) put(8'hFF, 8'hFF, 5);
        put(8'hFF, code, 5);
        if (code[4:0] != 5'h05) begin
          st = 1; fail = 1;
        end else begin
          busy_seq((b == to_blk) ? LIM : busy_k, fb, 6, to);
          if (to) begin st = 2; fail = 1; end
        end
      end
    end
    if (!fail && multi) begin
      put(8'hFF, 8'hFF, 7);
      put(8'hFD, 8'hFF, 7);
      busy_seq(stop_k, fb, 7, to);
      if (to) st = 2;
    end
    c_status[c] = st;
    c_end[c]    = ne;
  endtask

  // payload stream source
  always @(posedge clk_i) if (rst_ni && data_valid_i && data_ready_o) pidx <= pidx + 1;

  initial begin
    data_valid_i = 0; data_i = 0;
    forever begin
      @(negedge clk_i);
      data_valid_i = ($urandom_range(0, 3) != 0);
      data_i       = pay[pidx % MAXE];
    end
  end

  // SPI shifter and scripted card
  initial begin
    int lat;
    logic [7:0] held;
    lat = -1; held = 0;
    xchg_done_i = 0; xchg_rx_i = 0;
    forever begin
      @(negedge clk_i);
      if (xchg_done_i) begin
        xchg_done_i = 0;
        lat = -1;
      end else if (rst_ni && xchg_req_o) begin
        if (lat < 0) begin
          lat  = $urandom_range(0, 2);
          held = xchg_tx_o;
        end
        if (lat == 0) begin
          chk(xchg_tx_o == held, "R10", "tx held while pending", xchg_tx_o, held);
          if (k >= ne) begin
            chk(0, "R10", "unexpected exchange", k, ne);
            xchg_rx_i = 8'hFF;
          end else begin
            chk(xchg_tx_o == exp_tx[k], tag_s(exp_tag[k]), $sformatf("tx byte #%0d", k),
                xchg_tx_o, exp_tx[k]);
            xchg_rx_i = exp_rx[k];
          end
          xchg_done_i = 1;
          k++;
          lat = -1;
        end else begin
          lat--;
        end
      end
    end
  end

  // end-of-run monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        if (dc >= NCASE) begin
          chk(0, "R8", "extra done pulse", dc, NCASE);
        end else begin
          chk(status_o == 2'(c_status[dc]),
              (c_status[dc] == 1) ? "R5" : (c_status[dc] == 2) ? "R6" : "R8",
              $sformatf("status case %0d", dc), status_o, c_status[dc]);
          chk(k == c_end[dc], c_multi[dc] ? "R7" : "R8",
              $sformatf("exchange count case %0d", dc), k, c_end[dc]);
          chk(!busy_o, "R8", "busy low at done", busy_o, 0);
        end
        dc++;
      end
    end
  end

  task automatic launch(input int c);
    start_i  = 1;
    multi_i  = c_multi[c];
    crc_on_i = c_crc[c];
    nblk_i   = NW'(c_nblk[c]);
    @(negedge clk_i);
    start_i = 0;
  endtask

  initial begin
    void'($urandom(32'h5D17A0C3));
    rst_ni = 0; start_i = 0; multi_i = 0; crc_on_i = 0; nblk_i = 0;

    //       c nblk mul crc rdly bad code   busy fb     to stop chain
    add_case(0, 3,  1,  1,  1,  -1, 8'h00, 2,   8'hFF, -1, 1,   0);
    add_case(1, 1,  0,  1,  0,  -1, 8'h00, 0,   8'hFF, -1, 0,   0);
    add_case(2, 1,  0,  0,  7,  -1, 8'h00, LIM-2, 8'h00, -1, 0, 0);
    add_case(3, 2,  1,  1,  8,  -1, 8'h00, 1,   8'hFF, -1, 1,   1);
    add_case(4, 3,  1,  1,  0,   1, 8'h0B, 1,   8'h00, -1, 1,   1);
    add_case(5, 1,  0,  1,  2,   0, 8'h0D, 1,   8'hFF, -1, 0,   0);
    add_case(6, 2,  1,  1,  0,  -1, 8'h00, 0,   8'hFF,  1, 0,   0);
    add_case(7, 2,  1,  0,  3,  -1, 8'h00, 3,   8'h00, -1, LIM, 1);
    add_case(8, 0,  0,  1,  0,  -1, 8'h00, 0,   8'h00, -1, 0,   0);
    for (int c = 9; c < NCASE; c++)
      add_case(c, $urandom_range(1, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(0, TRIES - 1), -1, 8'h00, $urandom_range(0, LIM - 2),
               $urandom_range(0, 1) ? 8'hFF : 8'h00, -1, $urandom_range(0, LIM - 2),
               1'($urandom_range(0, 1)));

    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o,       "R1", "busy after reset",  busy_o, 0);
    chk(!done_o,       "R1", "done after reset",  done_o, 0);
    chk(!xchg_req_o,   "R1", "req after reset",   xchg_req_o, 0);
    chk(!data_ready_o, "R1", "ready after reset", data_ready_o, 0);

    for (int c = 0; c < NCASE; c++) begin
      if (c > 0) begin
        if (c_chain[c]) begin
          // R9: start lands in the done cycle of the previous run
          do @(negedge clk_i); while (!done_o);
        end else begin
          wait (dc == c);
          repeat (3) @(negedge clk_i);
        end
      end
      launch(c);
      if (c == 0) begin
        repeat (15) @(negedge clk_i);
        chk(busy_o, "R9", "run active before stray start", busy_o, 1);
        start_i = 1; multi_i = 0; crc_on_i = 0; nblk_i = 1;
        @(negedge clk_i);
        start_i = 0;
        chk(busy_o, "R9", "stray start leaves run going", busy_o, 1);
      end
    end

    wait (dc == NCASE);
    repeat (5) @(negedge clk_i);
    chk(k == ne,    "R7", "total exchanges", k, ne);
    chk(pidx == np, "R3", "payload bytes consumed", pidx, np);
    chk(!busy_o,    "R8", "idle at end", busy_o, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", dc, NCASE);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule